// File: doc/BRIEF.md
# Interleaved Converter Core Combiner

This block merges the samples of several slower converter cores into one stream at the full output rate. Four phase slots are served in strict round-robin order. Slot k carries the core that samples a quarter of a core period after the core in slot k-1, so the output sample count is four times that of a single core. Each selected sample first has its core's offset subtracted. The difference is then multiplied by that core's gain and saturated to the sample width.

A fifth core is kept as a spare. In background operation exactly one core is out of the active set at any time, so a calibration engine can trim it. When the engine reports that the spare core is done, the combiner swaps it in at the next round-robin boundary. The incoming core takes over the phase slot of the core it replaces, and the replaced core becomes the new spare. The replaced core is always the one after the spare in index order, modulo five. The output never pauses, skips or repeats a slot during a swap.

In foreground calibration the upstream logic raises a hold input. While the hold is high, sampling stops, the output value stays frozen and the valid strobe is low.

Top module: `ilvCombiner`

## Requirements
- R1: While reset is asserted, `outValid` is 0 and `outData` is 0.
- R2: After reset the phase slots 0, 1, 2 and 3 carry cores 0, 1, 2 and 3, and core 4 is the spare. Each output sample is tagged with its slot on `outSlot`.
- R3: Each output equals floor(((x - offset) * gain) / 2^15), saturated to the signed 16-bit range. Here x and offset are signed 16-bit values, gain is signed Q1.15 (0x8000 = -1.0, 0x4000 = 0.5), and the coefficients are those of the core in that slot.
- R4: While not held, `outValid` is 1 every cycle and `outSlot` advances by one, modulo 4, on every cycle. No slot is skipped or repeated, including across swaps.
- R5: When `bgEn` is 1, a `calDone` pulse whose `calDoneCore` equals the current spare marks a swap as pending. The swap happens only at the next round-robin boundary. The outgoing core is (spare + 1) mod 5, the spare takes over the outgoing core's slot, and the outgoing core becomes the spare. The frame already started when the pulse arrives still uses the old assignment.
- R6: A `calDone` pulse whose index is not the spare, or any `calDone` pulse while `bgEn` is 0, leaves the slot assignment unchanged.
- R7: A qualifying `calDone` pulse in the cycle in which the last slot (slot 3) is being selected takes effect at that same boundary. The output path has a latency of two clock edges, so this cycle is the one in which `outSlot` shows 1.
- R8: While `fgHold` is 1, `outValid` is 0 and `outData` stays unchanged from the cycle after `fgHold` is seen. After release, the first valid sample carries the slot that follows the last slot output before the hold.
- R9: With a DC input and offsets that exactly cancel each core's own offset error, the output is constant over many frames. There is no pattern repeating at 1/4 or 1/2 of the output rate.
- R10: After five consecutive swaps the spare is core 4 again, and the slots carry cores 3, 0, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output-rate clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bgEn | input | 1 | 1 = background operation with spare rotation |
| fgHold | input | 1 | Foreground hold: freeze sampling and output |
| coreData | input | 80 | Five signed 16-bit core samples, core c at bits [16c+15:16c] |
| coreValid | input | 5 | Per-core sample valid |
| coreOffset | input | 80 | Five signed 16-bit offsets, same packing as coreData |
| coreGain | input | 80 | Five signed Q1.15 gains, same packing |
| calDone | input | 1 | One-cycle pulse: calibration of a core finished |
| calDoneCore | input | 3 | Index of the core that finished calibration |
| outData | output | 16 | Corrected, interleaved sample |
| outValid | output | 1 | Sample valid |
| outSlot | output | 2 | Phase slot of the current sample |

## Verification
The interesting collision is a calibration-done pulse that lands in the very cycle the round-robin counter wraps from the last slot to the first. The bench provokes it by watching `outSlot` and firing the pulse when it shows 1, which is when slot 3 is being selected. It then requires the very next frame to show the new assignment, with every slot present once. A second test fires the pulse at the start of a frame and requires that one whole frame still uses the old assignment before the change appears, so a swap can never split a frame.

// File: rtl/ilvCombPkg.sv
package ilvCombPkg;
  // Active phase slots and total cores including the spare.
  localparam int NUM_ACT   = 4;
  localparam int NUM_CORES = NUM_ACT + 1;
  localparam int SLOT_W    = $clog2(NUM_ACT);
  localparam int CORE_W    = $clog2(NUM_CORES);

  typedef logic [CORE_W-1:0] coreIdx_t;
  typedef logic [SLOT_W-1:0] slot_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic     advance;  // pipeline moves this cycle
    coreIdx_t core;     // core selected for the current slot
    slot_t    slot;     // phase slot being selected
  } pathCtrl_t;
endpackage

// File: rtl/ilvCombCtrl.sv
module ilvCombCtrl
  import ilvCombPkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       bgEn,
  input  logic                       fgHold,
  input  logic                       calDone,
  input  coreIdx_t                   calDoneCore,
  output pathCtrl_t                  pathCtrl,
  output coreIdx_t                   spareCore,
  output logic [NUM_ACT*CORE_W-1:0]  slotMapFlat
);
  localparam slot_t    LAST_SLOT = slot_t'(NUM_ACT - 1);
  localparam coreIdx_t LAST_CORE = coreIdx_t'(NUM_CORES - 1);

  coreIdx_t slotMap [NUM_ACT];
  slot_t    slotCnt;
  logic     pending;
  logic     advance;
  logic     boundary;
  logic     hit;
  logic     doSwap;
  coreIdx_t outgoing;

  assign advance  = !fgHold;
  assign boundary = advance && (slotCnt == LAST_SLOT);
  assign hit      = calDone && bgEn && (calDoneCore == spareCore);
  assign outgoing = (spareCore == LAST_CORE) ? '0 : coreIdx_t'(spareCore + 1'b1);
  assign doSwap   = boundary && bgEn && (pending || hit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotCnt   <= '0;
      pending   <= 1'b0;
      spareCore <= LAST_CORE;
      for (int k = 0; k < NUM_ACT; k++) slotMap[k] <= coreIdx_t'(k);
    end else begin
      if (advance) slotCnt <= boundary ? '0 : slot_t'(slotCnt + 1'b1);

      if (!bgEn || doSwap) pending <= 1'b0;
      else if (hit)        pending <= 1'b1;

      if (doSwap) begin
        spareCore <= outgoing;
        for (int k = 0; k < NUM_ACT; k++)
          if (slotMap[k] == outgoing) slotMap[k] <= spareCore;
      end
    end
  end

  for (genvar k = 0; k < NUM_ACT; k++) begin : g_mapOut
    assign slotMapFlat[k*CORE_W +: CORE_W] = slotMap[k];
  end

  always_comb begin
    pathCtrl.advance = advance;
    pathCtrl.core    = slotMap[slotCnt];
    pathCtrl.slot    = slotCnt;
  end
endmodule

// File: rtl/ilvCombPath.sv
module ilvCombPath
  import ilvCombPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int GAIN_W = 16,
  parameter int FRAC_W = 15
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  pathCtrl_t                     pathCtrl,
  input  logic [NUM_CORES*DATA_W-1:0]   coreData,
  input  logic [NUM_CORES-1:0]          coreValid,
  input  logic [NUM_CORES*DATA_W-1:0]   coreOffset,
  input  logic [NUM_CORES*GAIN_W-1:0]   coreGain,
  output logic signed [DATA_W-1:0]      outData,
  output logic                          outValid,
  output slot_t                         outSlot
);
  localparam int DIFF_W = DATA_W + 1;
  localparam int PROD_W = DIFF_W + GAIN_W;
  localparam logic signed [PROD_W-1:0] SAT_HI =
    PROD_W'((longint'(1) <<< (DATA_W - 1)) - 1);
  localparam logic signed [PROD_W-1:0] SAT_LO =
    PROD_W'(-(longint'(1) <<< (DATA_W - 1)));

  logic signed [DATA_W-1:0] xs   [NUM_CORES];
  logic signed [DATA_W-1:0] offs [NUM_CORES];
  logic signed [GAIN_W-1:0] gns  [NUM_CORES];

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_unpack
    assign xs[c]   = coreData[c*DATA_W +: DATA_W];
    assign offs[c] = coreOffset[c*DATA_W +: DATA_W];
    assign gns[c]  = coreGain[c*GAIN_W +: GAIN_W];
  end

  // Stage 1: select the slot's core and remove its offset.
  logic signed [DIFF_W-1:0] selDiff;
  logic signed [DIFF_W-1:0] s1Diff;
  logic signed [GAIN_W-1:0] s1Gain;
  slot_t                    s1Slot;
  logic                     s1Vld;

  always_comb begin
    selDiff = DIFF_W'(xs[pathCtrl.core]) - DIFF_W'(offs[pathCtrl.core]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Diff <= '0;
      s1Gain <= '0;
      s1Slot <= '0;
      s1Vld  <= 1'b0;
    end else if (pathCtrl.advance) begin
      s1Diff <= selDiff;
      s1Gain <= gns[pathCtrl.core];
      s1Slot <= pathCtrl.slot;
      s1Vld  <= coreValid[pathCtrl.core];
    end
  end

  // Stage 2: scale by gain, drop the fraction, saturate.
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] scaled;
  logic signed [DATA_W-1:0] satVal;

  always_comb begin
    prod   = PROD_W'(s1Diff) * PROD_W'(s1Gain);
    scaled = prod >>> FRAC_W;
    if (scaled > SAT_HI)      satVal = SAT_HI[DATA_W-1:0];
    else if (scaled < SAT_LO) satVal = SAT_LO[DATA_W-1:0];
    else                      satVal = scaled[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outData  <= '0;
      outSlot  <= '0;
      outValid <= 1'b0;
    end else if (pathCtrl.advance) begin
      outData  <= satVal;
      outSlot  <= s1Slot;
      outValid <= s1Vld;
    end else begin
      outValid <= 1'b0;
    end
  end
endmodule

// File: rtl/ilvCombiner.sv
module ilvCombiner
  import ilvCombPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int GAIN_W = 16,
  parameter int FRAC_W = 15
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          bgEn,
  input  logic                          fgHold,
  input  logic [NUM_CORES*DATA_W-1:0]   coreData,
  input  logic [NUM_CORES-1:0]          coreValid,
  input  logic [NUM_CORES*DATA_W-1:0]   coreOffset,
  input  logic [NUM_CORES*GAIN_W-1:0]   coreGain,
  input  logic                          calDone,
  input  logic [CORE_W-1:0]             calDoneCore,
  output logic signed [DATA_W-1:0]      outData,
  output logic                          outValid,
  output logic [SLOT_W-1:0]             outSlot
);
  pathCtrl_t                   pathCtrl;
  coreIdx_t                    spareCore;
  logic [NUM_ACT*CORE_W-1:0]   slotMapFlat;

  ilvCombCtrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .bgEn        (bgEn),
    .fgHold      (fgHold),
    .calDone     (calDone),
    .calDoneCore (calDoneCore),
    .pathCtrl    (pathCtrl),
    .spareCore   (spareCore),
    .slotMapFlat (slotMapFlat)
  );

  ilvCombPath #(
    .DATA_W (DATA_W),
    .GAIN_W (GAIN_W),
    .FRAC_W (FRAC_W)
  ) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .pathCtrl   (pathCtrl),
    .coreData   (coreData),
    .coreValid  (coreValid),
    .coreOffset (coreOffset),
    .coreGain   (coreGain),
    .outData    (outData),
    .outValid   (outValid),
    .outSlot    (outSlot)
  );
endmodule

// File: rtl/ilvCombinerChk.sv
module ilvCombinerChk
  import ilvCombPkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        bgEn,
  input logic                        fgHold,
  input logic                        outValid,
  input logic [DATA_W-1:0]           outData,
  input logic [SLOT_W-1:0]           outSlot,
  input logic [CORE_W-1:0]           spareCore,
  input logic [NUM_ACT*CORE_W-1:0]   slotMapFlat,
  input logic [SLOT_W-1:0]           ctrlSlot
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_ACT - 1);

  logic [NUM_CORES-1:0] inMap;
  always_comb begin
    inMap = '0;
    for (int k = 0; k < NUM_ACT; k++)
      if (int'(slotMapFlat[k*CORE_W +: CORE_W]) < NUM_CORES)
        inMap[slotMapFlat[k*CORE_W +: CORE_W]] = 1'b1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rstN |-> (!outValid && outData == '0));

  // R4
  slot_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !fgHold) |=>
      (outSlot == (($past(outSlot) == LAST_SLOT) ? '0 : SLOT_W'($past(outSlot) + 1'b1))));

  // R5
  spare_excluded_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!inMap[spareCore] && $countones(inMap) == NUM_ACT));

  // R5
  swap_on_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    (spareCore != $past(spareCore)) |-> ($past(ctrlSlot) == LAST_SLOT));

  // R6
  fg_config_static_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bgEn |=> $stable(spareCore));

  // R8
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    fgHold |=> (!outValid && $stable(outData)));
endmodule

bind ilvCombiner ilvCombinerChk #(.DATA_W(DATA_W)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .bgEn        (bgEn),
  .fgHold      (fgHold),
  .outValid    (outValid),
  .outData     (outData),
  .outSlot     (outSlot),
  .spareCore   (spareCore),
  .slotMapFlat (slotMapFlat),
  .ctrlSlot    (pathCtrl.slot)
);

// File: tb/tb_ilvCombiner.sv
module tb_ilvCombiner;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 5;
  localparam int NA = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bgEn = 1'b1;
  logic fgHold = 1'b0;
  logic calDone = 1'b0;
  logic [2:0] calDoneCore = '0;
  logic [NC*16-1:0] coreData, coreOffset, coreGain;
  logic [NC-1:0] coreValid = '1;
  logic signed [15:0] outData;
  logic outValid;
  logic [1:0] outSlot;

  int raw [NC];
  int off [NC];
  int gn  [NC];
  int bMap [NA];
  int bSpare;
  int nChecks = 0;
  int nFails = 0;
  logic monOn = 1'b0;
  logic havePrev = 1'b0;
  int prevSlot = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int c = 0; c < NC; c++) begin
      coreData[c*16 +: 16]   = 16'(raw[c]);
      coreOffset[c*16 +: 16] = 16'(off[c]);
      coreGain[c*16 +: 16]   = 16'(gn[c]);
    end
  end

  ilvCombiner dut (
    .clk(clk), .rstN(rstN), .bgEn(bgEn), .fgHold(fgHold),
    .coreData(coreData), .coreValid(coreValid), .coreOffset(coreOffset),
    .coreGain(coreGain), .calDone(calDone), .calDoneCore(calDoneCore),
    .outData(outData), .outValid(outValid), .outSlot(outSlot)
  );

  task automatic checkEq(string req, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int corr(int x, int o, int g);
    longint d = longint'(x) - longint'(o);
    longint p = (d * longint'(g)) >>> 15;
    if (p > 32767) return 32767;
    if (p < -32768) return -32768;
    return int'(p);
  endfunction

  function automatic void modelSwap();
    int outg = (bSpare == NC - 1) ? 0 : bSpare + 1;
    for (int k = 0; k < NA; k++) if (bMap[k] == outg) bMap[k] = bSpare;
    bSpare = outg;
  endfunction

  // R4: continuous, gapless slot sequence while running
  always @(negedge clk) begin
    if (monOn && !done) begin
      if (havePrev) begin
        checkEq("R4 valid", longint'(outValid), 1);
        checkEq("R4 slot step", longint'(outSlot), longint'((prevSlot + 1) % NA));
      end
      prevSlot = int'(outSlot);
      havePrev = 1'b1;
    end else begin
      havePrev = 1'b0;
    end
  end

  task automatic grabFrame(output int v[NA]);
    do @(negedge clk); while (!(outValid && outSlot == 2'd0));
    v[0] = int'(outData);
    for (int k = 1; k < NA; k++) begin
      @(negedge clk);
      v[k] = int'(outData);
    end
  endtask

  task automatic checkFrame(string req);
    int v[NA];
    grabFrame(v);
    for (int k = 0; k < NA; k++)
      checkEq(req, longint'(v[k]), longint'(corr(raw[bMap[k]], off[bMap[k]], gn[bMap[k]])));
  endtask

  task automatic pulseAt(int idx, int atOutSlot);
    do @(negedge clk); while (!(outValid && int'(outSlot) == atOutSlot));
    calDone = 1'b1;
    calDoneCore = 3'(idx);
    @(negedge clk);
    calDone = 1'b0;
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    checkEq("R1 valid", longint'(outValid), 0);
    checkEq("R1 data", longint'(outData), 0);
    rstN = 1'b1;
  endtask

  task automatic testOrder();
    checkFrame("R2 order");
    checkFrame("R2 order repeat");
    monOn = 1'b1;
  endtask

  task automatic testCorrection();
    int v[NA];
    raw[0] = 32767;  off[0] = -32768; gn[0] = 32767;
    raw[1] = -32768; off[1] = 32767;  gn[1] = 32767;
    raw[2] = 100;    off[2] = 20;     gn[2] = -32768;
    raw[3] = -7;     off[3] = 0;      gn[3] = 16384;
    repeat (6) @(negedge clk);
    grabFrame(v);
    checkEq("R3 sat high", longint'(v[0]), 32767);
    checkEq("R3 sat low", longint'(v[1]), -32768);
    checkEq("R3 negative gain", longint'(v[2]), -80);
    checkEq("R3 floor", longint'(v[3]), -4);
    for (int c = 0; c < NC; c++) begin
      raw[c] = 1000 * (c + 1) + 7 * c;
      off[c] = 10 * c;
      gn[c] = 16384 + 1000 * c;
    end
    repeat (6) @(negedge clk);
    checkFrame("R3 mixed coeffs");
  endtask

  task automatic testIgnored();
    pulseAt(2, 1);
    checkFrame("R6 wrong index");
    checkFrame("R6 wrong index later");
    bgEn = 1'b0;
    pulseAt(bSpare, 1);
    checkFrame("R6 fg config");
    checkFrame("R6 fg config later");
    bgEn = 1'b1;
  endtask

  task automatic testSwapMidFrame(string tag);
    pulseAt(bSpare, 2);
    checkFrame({tag, " old frame"});
    modelSwap();
    checkFrame({tag, " new frame"});
  endtask

  // R7: pulse in the boundary cycle applies at once
  task automatic testSwapOnBoundary();
    pulseAt(bSpare, 1);
    modelSwap();
    checkFrame("R7 boundary pulse");
  endtask

  task automatic testFullRotation();
    testSwapMidFrame("R10");
    checkEq("R10 spare", longint'(bSpare), 4);
    checkEq("R10 slot0", longint'(bMap[0]), 3);
    checkEq("R10 slot1", longint'(bMap[1]), 0);
    checkEq("R10 slot2", longint'(bMap[2]), 1);
    checkEq("R10 slot3", longint'(bMap[3]), 2);
    checkFrame("R10 frame");
  endtask

  task automatic testHold();
    int held;
    int lastSlot;
    do @(negedge clk); while (!outValid);
    monOn = 1'b0;
    held = int'(outData);
    lastSlot = int'(outSlot);
    fgHold = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      checkEq("R8 valid low", longint'(outValid), 0);
      checkEq("R8 data frozen", longint'(outData), longint'(held));
    end
    fgHold = 1'b0;
    @(negedge clk);
    checkEq("R8 resume valid", longint'(outValid), 1);
    checkEq("R8 resume slot", longint'(outSlot), longint'((lastSlot + 1) % NA));
    checkFrame("R8 after hold");
    monOn = 1'b1;
  endtask

  task automatic testDcFlat();
    int first;
    int diffs = 0;
    for (int c = 0; c < NC; c++) begin
      off[c] = 13 * c - 20;
      raw[c] = 500 + off[c];
      gn[c] = 32767;
    end
    repeat (6) @(negedge clk);
    do @(negedge clk); while (!outValid);
    first = int'(outData);
    checkEq("R9 dc level", longint'(first), longint'(corr(500, 0, 32767)));
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (int'(outData) != first) diffs++;
    end
    checkEq("R9 no periodic pattern", longint'(diffs), 0);
  endtask

  initial begin
    for (int c = 0; c < NC; c++) begin
      raw[c] = 1000 * (c + 1) + 7 * c;
      off[c] = 0;
      gn[c] = 16384;
    end
    for (int k = 0; k < NA; k++) bMap[k] = k;
    bSpare = 4;
    testReset();
    testOrder();
    testCorrection();
    testIgnored();
    testSwapMidFrame("R5 spare4");
    testSwapMidFrame("R5 spare0");
    testSwapOnBoundary();
    testSwapOnBoundary();
    testFullRotation();
    testHold();
    testDcFlat();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    done = 1'b1;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule